// File: doc/BRIEF.md
# Accumulator Fetch-Decode-Execute Sequencer

This block is a small multi-cycle processor core built around a single accumulator. It steps each instruction through an explicit register-transfer sequence: the program counter is copied into the memory address register, memory is read into the memory data register, the program counter advances, and the fetched byte moves into the current-instruction register. The instruction is then split into its fields and executed. Instructions and data live in one shared memory, reached over an 8-bit address bus and an 8-bit data bus through a synchronous port with one cycle of read latency.

Each instruction is one byte. Bits 7:5 are the operation, bit 4 is the addressing mode and bits 3:0 are the operand. Operations are LOAD=000, STORE=001, ADD=010, SUB=011, AND=100, JMP=101, JZ=110 and HALT=111. A mode bit of 0 makes the operand an immediate value. A mode bit of 1 makes it a memory address, zero-extended to 8 bits, whose contents are used instead. STORE always writes the accumulator to the zero-extended operand address, whatever the mode bit.

After every execute step the core polls an interrupt-pending bit in its status register. A rising edge on the request input sets that bit. If the bit is set at the poll, the core saves the program counter in a shadow register, clears the bit, continues fetching at address 0xF0, and raises an acknowledge for one cycle.

Top module: `acc_fde_core`

## Requirements
- R1: While reset is held, memWrEn and irqAck are 0, memAddr is 0 and irqRetPc is 0. The first instruction fetched after reset comes from address 0.
- R2: Instructions are fetched from consecutive addresses. Each is decoded as operation = bits 7:5, mode = bit 4, operand = bits 3:0.
- R3: With mode 0, the operand (bits 3:0, zero-extended) is the data value. With mode 1, the byte stored at the zero-extended operand address is the data value.
- R4: ADD, SUB and AND combine the accumulator with the data value modulo 256, and LOAD replaces the accumulator with it.
- R5: STORE writes the accumulator to the zero-extended operand address with a write strobe lasting exactly one cycle.
- R6: JMP sets the program counter to the data value. JZ does so only when the last LOAD, ADD, SUB or AND result was zero, and otherwise falls through.
- R7: An instruction with no memory operand takes 7 cycles. One with a direct-mode data read (LOAD, ADD, SUB, AND, JMP or JZ with mode 1) takes 9 cycles.
- R8: A rising edge on irqReq is serviced at the next poll after an execute step. irqAck is high for one cycle, irqRetPc then holds the address of the next instruction, and fetching resumes at 0xF0. irqAck never rises without a request.
- R9: A request held high for many cycles is serviced only once.
- R10: After HALT the core performs no writes, keeps memAddr constant and ignores interrupt requests until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | 8 | Memory address, driven from the address register |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 8 | Write data (accumulator) |
| memRdData | input | 8 | Read data, valid one cycle after the address |
| irqReq | input | 1 | Interrupt request, rising-edge sensitive |
| irqAck | output | 1 | One-cycle acknowledge when the interrupt is taken |
| irqRetPc | output | 8 | Saved program counter of the interrupted program |

## Verification
The hardest case to reach from the ports is an interrupt request that stays high across several whole instructions. A level-sensitive mistake would only show up as a second, nested service. To expose it, the bench holds the request high through a 9-cycle direct-mode load. The handler at 0xF0 then jumps back into the main program, so any extra service would change the stored results and the acknowledge count. Instruction timing is measured from the cycle gaps between the write strobes of successive stores, placed around instructions with and without a memory operand.

// File: rtl/acc_fde_pkg.sv
package acc_fde_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ADD   = 3'd2,
    OP_SUB   = 3'd3,
    OP_AND   = 3'd4,
    OP_JMP   = 3'd5,
    OP_JZ    = 3'd6,
    OP_HALT  = 3'd7
  } opCode_e;

  typedef enum logic [3:0] {
    ST_F_ADDR,
    ST_F_READ,
    ST_F_CAPT,
    ST_F_LOAD,
    ST_DECODE,
    ST_X_READ,
    ST_X_CAPT,
    ST_EXEC,
    ST_IRQ_CHK,
    ST_HALT
  } seqState_e;

  typedef struct packed {
    logic marFromPc;
    logic marFromOpd;
    logic pcInc;
    logic mdrCapt;
    logic cirLoad;
    logic execAlu;
    logic memWr;
    logic pcJump;
    logic irqTake;
  } ctrlStrobe_t;

endpackage

// File: rtl/acc_fde_ctrl.sv
module acc_fde_ctrl
  import acc_fde_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  opCode_e     op,
  input  logic        modeDirect,
  input  logic        zeroFlag,
  input  logic        irqPend,
  output ctrlStrobe_t strb,
  output logic        halted
);

  seqState_e stateQ, stateD;
  logic      needsData;

  assign needsData = (op != OP_STORE) && (op != OP_HALT);
  assign halted    = (stateQ == ST_HALT);

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_F_ADDR;
    else       stateQ <= stateD;
  end

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_F_ADDR: begin
        strb.marFromPc = 1'b1;
        stateD = ST_F_READ;
      end
      ST_F_READ: begin
        strb.pcInc = 1'b1;
        stateD = ST_F_CAPT;
      end
      ST_F_CAPT: begin
        strb.mdrCapt = 1'b1;
        stateD = ST_F_LOAD;
      end
      ST_F_LOAD: begin
        strb.cirLoad = 1'b1;
        stateD = ST_DECODE;
      end
      ST_DECODE: begin
        if (op == OP_STORE || (modeDirect && needsData)) strb.marFromOpd = 1'b1;
        stateD = (modeDirect && needsData) ? ST_X_READ : ST_EXEC;
      end
      ST_X_READ: stateD = ST_X_CAPT;
      ST_X_CAPT: begin
        strb.mdrCapt = 1'b1;
        stateD = ST_EXEC;
      end
      ST_EXEC: begin
        stateD = ST_IRQ_CHK;
        case (op)
          OP_HALT:  stateD = ST_HALT;
          OP_STORE: strb.memWr = 1'b1;
          OP_JMP:   strb.pcJump = 1'b1;
          OP_JZ:    strb.pcJump = zeroFlag;
          default:  strb.execAlu = 1'b1;
        endcase
      end
      ST_IRQ_CHK: begin
        strb.irqTake = irqPend;
        stateD = ST_F_ADDR;
      end
      ST_HALT: stateD = ST_HALT;
      default: stateD = ST_F_ADDR;
    endcase
  end

endmodule

// File: rtl/acc_fde_dpath.sv
module acc_fde_dpath
  import acc_fde_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              irqReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output opCode_e           op,
  output logic              modeDirect,
  output logic              zeroFlag,
  output logic              irqPend,
  output logic [ADDR_W-1:0] irqRetPc
);

  localparam int unsigned OP_W   = 3;
  localparam int unsigned OPND_W = DATA_W - OP_W - 1;
  localparam int unsigned MODE_B = OPND_W;

  logic [ADDR_W-1:0] pcQ, marQ, shadowQ;
  logic [DATA_W-1:0] mdrQ, cirQ, accQ;
  logic              zeroQ, carryQ, pendQ, reqPrevQ;

  logic [OPND_W-1:0] opnd;
  logic [DATA_W-1:0] opVal;
  logic [DATA_W:0]   aluWide;
  logic              reqRise;

  assign op         = opCode_e'(cirQ[DATA_W-1 -: OP_W]);
  assign modeDirect = cirQ[MODE_B];
  assign opnd       = cirQ[OPND_W-1:0];
  assign opVal      = modeDirect ? mdrQ : DATA_W'(opnd);
  assign reqRise    = irqReq && !reqPrevQ;

  assign memAddr   = marQ;
  assign memWrData = accQ;
  assign zeroFlag  = zeroQ;
  assign irqPend   = pendQ;
  assign irqRetPc  = shadowQ;

  always_comb begin
    case (op)
      OP_ADD:  aluWide = {1'b0, accQ} + {1'b0, opVal};
      OP_SUB:  aluWide = {1'b0, accQ} - {1'b0, opVal};
      OP_AND:  aluWide = {carryQ, accQ & opVal};
      default: aluWide = {carryQ, opVal};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ      <= '0;
      marQ     <= '0;
      mdrQ     <= '0;
      cirQ     <= '0;
      accQ     <= '0;
      zeroQ    <= 1'b0;
      carryQ   <= 1'b0;
      pendQ    <= 1'b0;
      reqPrevQ <= 1'b0;
      shadowQ  <= '0;
    end else begin
      reqPrevQ <= irqReq;
      pendQ    <= reqRise || (pendQ && !strb.irqTake);
      if (strb.marFromPc)  marQ <= pcQ;
      if (strb.marFromOpd) marQ <= ADDR_W'(opnd);
      if (strb.mdrCapt)    mdrQ <= memRdData;
      if (strb.cirLoad)    cirQ <= mdrQ;
      if (strb.pcInc)      pcQ  <= pcQ + 1'b1;
      if (strb.pcJump)     pcQ  <= ADDR_W'(opVal);
      if (strb.execAlu) begin
        accQ   <= aluWide[DATA_W-1:0];
        zeroQ  <= (aluWide[DATA_W-1:0] == '0);
        carryQ <= aluWide[DATA_W];
      end
      if (strb.irqTake) begin
        shadowQ <= pcQ;
        pcQ     <= IRQ_VEC;
      end
    end
  end

endmodule

// File: rtl/acc_fde_core.sv
module acc_fde_core
  import acc_fde_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              irqReq,
  output logic              irqAck,
  output logic [ADDR_W-1:0] irqRetPc
);

  ctrlStrobe_t strb;
  opCode_e     opW;
  logic        modeW, zeroW, pendW, haltedW;

  acc_fde_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .op        (opW),
    .modeDirect(modeW),
    .zeroFlag  (zeroW),
    .irqPend   (pendW),
    .strb      (strb),
    .halted    (haltedW)
  );

  acc_fde_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IRQ_VEC(IRQ_VEC)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .memRdData (memRdData),
    .irqReq    (irqReq),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .op        (opW),
    .modeDirect(modeW),
    .zeroFlag  (zeroW),
    .irqPend   (pendW),
    .irqRetPc  (irqRetPc)
  );

  assign memWrEn = strb.memWr;
  assign irqAck  = strb.irqTake;

endmodule

// File: rtl/acc_fde_chk.sv
module acc_fde_chk #(
  parameter int unsigned ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] IRQ_VEC = 8'hF0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWrEn,
  input logic              irqAck,
  input logic [ADDR_W-1:0] irqRetPc,
  input logic              halted
);

  // R8: acknowledge lasts one cycle
  a_r8_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> !irqAck);

  // R8: fetching resumes at the vector
  a_r8_ack_vector: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> ##1 (memAddr == IRQ_VEC));

  // R8: saved return address changes only when an interrupt is taken
  a_r8_retpc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !irqAck |=> $stable(irqRetPc));

  // R5: write strobe is a single-cycle pulse
  a_r5_write_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn);

  // R10: halted core stays frozen
  a_r10_halt_frozen: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && !memWrEn && !irqAck && $stable(memAddr)));

endmodule

bind acc_fde_core acc_fde_chk #(
  .ADDR_W (ADDR_W),
  .IRQ_VEC(IRQ_VEC)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .memAddr (memAddr),
  .memWrEn (memWrEn),
  .irqAck  (irqAck),
  .irqRetPc(irqRetPc),
  .halted  (haltedW)
);

// File: tb/acc_fde_core_tb.sv
module acc_fde_core_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] memAddr, memWrData, memRdData;
  logic       memWrEn, irqReq, irqAck;
  logic [7:0] irqRetPc;

  logic [7:0] image [256];
  logic [7:0] mem   [256];

  int checks = 0;
  int failures = 0;
  int cyc, wrN, ackN, totalCyc;
  int wrCyc [8];

  always #2 clk = ~clk;

  acc_fde_core dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .memAddr  (memAddr),
    .memWrEn  (memWrEn),
    .memWrData(memWrData),
    .memRdData(memRdData),
    .irqReq   (irqReq),
    .irqAck   (irqAck),
    .irqRetPc (irqRetPc)
  );

  // memory model: one-cycle synchronous read, loaded from image during reset
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= image[i];
    end else if (memWrEn) begin
      mem[memAddr] <= memWrData;
    end
    memRdData <= mem[memAddr];
  end

  always @(negedge clk) begin
    if (!rstN) begin
      cyc = 0; wrN = 0; ackN = 0;
    end else begin
      if (memWrEn) begin
        if (wrN < 8) wrCyc[wrN] = cyc;
        wrN++;
      end
      if (irqAck) ackN++;
      cyc++;
    end
  end

  always @(posedge clk) begin
    totalCyc++;
    if (totalCyc > 40000) begin
      failures++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 40000)", totalCyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [7:0] ins(logic [2:0] op, logic m, logic [3:0] v);
    return {op, m, v};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clearImage();
    for (int i = 0; i < 256; i++) image[i] = 8'hE0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    irqReq = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    clearImage();
    @(negedge clk);
    rstN = 1'b0;
    irqReq = 1'b0;
    repeat (3) @(negedge clk);
    chk(memAddr == 8'h00, "R1 memAddr in reset", memAddr, 0);
    chk(!memWrEn && !irqAck, "R1 strobes in reset", {memWrEn, irqAck}, 0);
    chk(irqRetPc == 8'h00, "R1 irqRetPc in reset", irqRetPc, 0);
  endtask

  task automatic testImmediate();
    clearImage();
    image[0] = ins(3'd0, 1'b0, 4'd5);
    image[1] = ins(3'd2, 1'b0, 4'd7);
    image[2] = ins(3'd1, 1'b0, 4'hE);
    image[3] = ins(3'd3, 1'b0, 4'hF);
    image[4] = ins(3'd1, 1'b0, 4'hF);
    image[5] = ins(3'd4, 1'b0, 4'h9);
    image[6] = ins(3'd1, 1'b1, 4'hD);
    image[7] = ins(3'd7, 1'b0, 4'h0);
    doReset();
    runCycles(150);
    chk(mem[8'h0E] == 8'd12, "R2 R4 load+add immediate", mem[8'h0E], 12);
    chk(mem[8'h0F] == 8'hFD, "R4 sub wraps", mem[8'h0F], 8'hFD);
    chk(mem[8'h0D] == 8'h09, "R4 R5 and then store", mem[8'h0D], 8'h09);
    chk(wrN == 3, "R5 write count", wrN, 3);
    chk(ackN == 0, "R8 no ack without request", ackN, 0);
  endtask

  task automatic testDirect();
    clearImage();
    image[0] = ins(3'd0, 1'b1, 4'hA);
    image[1] = ins(3'd2, 1'b1, 4'hB);
    image[2] = ins(3'd1, 1'b0, 4'hC);
    image[3] = ins(3'd0, 1'b0, 4'hA);
    image[4] = ins(3'd1, 1'b0, 4'h9);
    image[5] = ins(3'd7, 1'b0, 4'h0);
    image[8'h0A] = 8'h80;
    image[8'h0B] = 8'h90;
    doReset();
    runCycles(150);
    chk(mem[8'h0C] == 8'h10, "R3 R4 direct load+add wraps", mem[8'h0C], 8'h10);
    chk(mem[8'h09] == 8'h0A, "R3 immediate uses operand", mem[8'h09], 8'h0A);
  endtask

  task automatic testTiming();
    clearImage();
    image[0] = ins(3'd0, 1'b0, 4'd3);
    image[1] = ins(3'd1, 1'b0, 4'h8);
    image[2] = ins(3'd1, 1'b0, 4'h9);
    image[3] = ins(3'd0, 1'b1, 4'h8);
    image[4] = ins(3'd1, 1'b0, 4'h7);
    image[5] = ins(3'd7, 1'b0, 4'h0);
    doReset();
    runCycles(120);
    chk(wrN == 3, "R7 write count", wrN, 3);
    chk(wrCyc[1] - wrCyc[0] == 7, "R7 no-operand instruction length", wrCyc[1] - wrCyc[0], 7);
    chk(wrCyc[2] - wrCyc[1] == 16, "R7 direct read adds two cycles", wrCyc[2] - wrCyc[1], 16);
    chk(mem[8'h07] == 8'd3, "R3 direct load of stored value", mem[8'h07], 3);
  endtask

  task automatic testJumps();
    clearImage();
    image[0]  = ins(3'd0, 1'b0, 4'd0);
    image[1]  = ins(3'd6, 1'b0, 4'd4);
    image[2]  = ins(3'd1, 1'b0, 4'hE);
    image[3]  = ins(3'd7, 1'b0, 4'h0);
    image[4]  = ins(3'd0, 1'b0, 4'd2);
    image[5]  = ins(3'd6, 1'b0, 4'd2);
    image[6]  = ins(3'd1, 1'b0, 4'hD);
    image[7]  = ins(3'd5, 1'b1, 4'hF);
    image[8]  = ins(3'd1, 1'b0, 4'hE);
    image[9]  = ins(3'd7, 1'b0, 4'h0);
    image[10] = ins(3'd1, 1'b0, 4'hC);
    image[11] = ins(3'd7, 1'b0, 4'h0);
    image[15] = 8'h0A;
    doReset();
    runCycles(200);
    chk(mem[8'h0E] == 8'hE0, "R6 JZ taken and JMP skip", mem[8'h0E], 8'hE0);
    chk(mem[8'h0D] == 8'h02, "R6 JZ not taken falls through", mem[8'h0D], 2);
    chk(mem[8'h0C] == 8'h02, "R6 direct JMP target", mem[8'h0C], 2);
  endtask

  task automatic testIrqPulse();
    clearImage();
    image[0] = ins(3'd0, 1'b0, 4'd6);
    image[1] = ins(3'd2, 1'b0, 4'd1);
    image[2] = ins(3'd1, 1'b0, 4'hD);
    image[3] = ins(3'd7, 1'b0, 4'h0);
    image[8'hF0] = ins(3'd1, 1'b0, 4'hE);
    image[8'hF1] = ins(3'd7, 1'b0, 4'h0);
    doReset();
    runCycles(2);
    irqReq = 1'b1;
    runCycles(1);
    irqReq = 1'b0;
    runCycles(120);
    chk(ackN == 1, "R8 one acknowledge", ackN, 1);
    chk(irqRetPc == 8'h01, "R8 saved return address", irqRetPc, 1);
    chk(mem[8'h0E] == 8'h06, "R8 vector code ran", mem[8'h0E], 6);
    chk(mem[8'h0D] == 8'hE0, "R8 main program left", mem[8'h0D], 8'hE0);
  endtask

  task automatic testIrqLevel();
    clearImage();
    image[0] = ins(3'd0, 1'b1, 4'h8);
    image[1] = ins(3'd1, 1'b0, 4'hD);
    image[2] = ins(3'd7, 1'b0, 4'h0);
    image[8]  = 8'h20;
    image[8'hF0] = ins(3'd2, 1'b0, 4'd1);
    image[8'hF1] = ins(3'd1, 1'b0, 4'hE);
    image[8'hF2] = ins(3'd5, 1'b0, 4'd1);
    doReset();
    runCycles(1);
    irqReq = 1'b1;
    runCycles(200);
    irqReq = 1'b0;
    runCycles(2);
    chk(ackN == 1, "R9 held request serviced once", ackN, 1);
    chk(mem[8'h0E] == 8'h21, "R9 handler result", mem[8'h0E], 8'h21);
    chk(mem[8'h0D] == 8'h21, "R9 return path result", mem[8'h0D], 8'h21);
    chk(irqRetPc == 8'h01, "R9 return address", irqRetPc, 1);
  endtask

  task automatic testHalt();
    int badAddr;
    clearImage();
    image[0] = ins(3'd7, 1'b0, 4'h0);
    doReset();
    runCycles(20);
    irqReq = 1'b1;
    runCycles(2);
    irqReq = 1'b0;
    badAddr = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (memAddr != 8'h00) badAddr++;
    end
    chk(badAddr == 0, "R10 address frozen", badAddr, 0);
    chk(wrN == 0, "R10 no writes", wrN, 0);
    chk(ackN == 0, "R10 interrupt ignored", ackN, 0);
  endtask

  initial begin
    irqReq = 1'b0;
    totalCyc = 0;
    testReset();
    testImmediate();
    testDirect();
    testTiming();
    testJumps();
    testIrqPulse();
    testIrqLevel();
    testHalt();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule